// File: doc/BRIEF.md
# Interleaved Channel Address Translator

This block turns a system physical address into the address seen by one DRAM channel. Each request is checked against eight programmable address windows. The first enabled window that holds the address decides how the address is handled. That window selects a logical channel from its own short interleave list, using one or two address bits at a programmable position. A shared table then maps the logical channel to a physical channel.

The selector bits are then cut out of the address, and the bits above them move down to fill the gap. The three byte-offset bits are dropped. What remains is split into column, bank, bank group, row and rank fields.

Configuration is written through a single-cycle register write port. A request enters through a valid/ready input. The result leaves through a registered valid/ready output that holds steady under backpressure. A request that hits no window returns an error response with every address field zero.

Top module: `chan_addr_xlat`

## Requirements
- R1: After reset, `reqReady` is 1, `respValid` is 0, every window is disabled and the channel map is the identity (logical k goes to physical k).
- R2: A window hits when its enable bit is 1 and base <= address <= limit, with both bounds inclusive. When several windows hit, the lowest-numbered one is used.
- R3: A request that hits no window returns `respErr`=1 with the physical channel and every address field equal to 0.
- R4: The window's ways code (control bits [2:1]) picks the interleave: 0 is one-way with list index 0, 1 is two-way with index = address bit P, and 2 or 3 is four-way with index = address bits P+1:P. P is control bits [8:3]. List entry k sits in control bits [10+2k:9+2k].
- R5: The logical channel read from the list is replaced by the physical channel in map bits [2L+1:2L], where L is the logical channel.
- R6: The selector bits (none, one or two, starting at P) are removed from the address. Bits below P keep their place, and bits above the removed ones shift down by the number removed.
- R7: After removal, bits [2:0] are dropped. Counting from the next bit upward, the layout is column (10 bits), bank (2 bits), bank group (BG_W), row (ROW_W), then rank (RANK_W).
- R8: A write with `cfgAddr[5]`=0 targets window `cfgAddr[4:2]`: sub-address 0 holds the base, 1 the limit and 2 the control word (enable in bit 0). A write with `cfgAddr[5]`=1 loads the channel map from `cfgData[7:0]`. A write takes effect for requests accepted after the write edge.
- R9: While `respValid`=1 and `respReady`=0, the response stays unchanged and `reqReady` is 0.
- R10: With `respReady` held at 1, a request is accepted on every cycle. Each accepted request appears at the output on the next cycle.
- R11: While `respValid`=0, `respErr`, the physical channel and all address fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | RULE_W+3 | Configuration register select |
| cfgData | input | ADDR_W | Configuration write data |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | System physical address |
| reqReady | output | 1 | Request accepted this cycle when valid |
| respValid | output | 1 | Response present |
| respReady | input | 1 | Response consumed this cycle when valid |
| respErr | output | 1 | No window matched |
| respPhysCh | output | 2 | Physical channel |
| respRank | output | RANK_W | Rank field |
| respBankGroup | output | BG_W | Bank group field |
| respBank | output | 2 | Bank field |
| respRow | output | ROW_W | Row field |
| respCol | output | 10 | Column field |

## Verification
The assertions assume that `respReady` may change at any time, and that the channel map may even be written as a non-permutation. They assume only that inputs are stable around the clock edge. The bench drives every input one nanosecond after the rising edge and samples at the falling edge. It also mixes random backpressure with random addresses, so that held responses, blocked requests and back-to-back acceptances all occur. Window bounds and selector positions are chosen so that addresses land on both sides of each inclusive limit.

// File: rtl/chan_xlat_pkg.sv
package chan_xlat_pkg;
  localparam int OFF_W  = 3;
  localparam int COL_W  = 10;
  localparam int BANK_W = 2;
  localparam int CH_W   = 2;
  localparam int NUM_CH = 1 << CH_W;
  localparam int POS_W  = 6;

  // bit 0 = enable, [2:1] = ways code, [8:3] = selector position, [16:9] = list
  typedef struct packed {
    logic [NUM_CH*CH_W-1:0] list;
    logic [POS_W-1:0]       selPos;
    logic [1:0]             waysCode;
    logic                   en;
  } ruleCtl_t;

  localparam int CTL_W = $bits(ruleCtl_t);

  typedef struct packed {
    logic load;
    logic drain;
  } xlatStrobe_t;
endpackage

// File: rtl/chan_xlat_range.sv
module chan_xlat_range #(
  parameter int ADDR_W = 40
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              hit
);
  always_comb hit = en && (addr >= base) && (addr <= limit);
endmodule

// File: rtl/chan_xlat_ctrl.sv
module chan_xlat_ctrl
  import chan_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        respReady,
  output logic        reqReady,
  output logic        respValid,
  output xlatStrobe_t strobe
);
  logic heldQ;

  always_comb begin
    reqReady     = !heldQ || respReady;
    strobe.load  = reqValid && reqReady;
    strobe.drain = heldQ && respReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             heldQ <= 1'b0;
    else if (strobe.load)  heldQ <= 1'b1;
    else if (strobe.drain) heldQ <= 1'b0;
  end

  assign respValid = heldQ;
endmodule

// File: rtl/chan_xlat_dp.sv
module chan_xlat_dp
  import chan_xlat_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NUM_RULES = 8,
  parameter int ROW_W     = 17,
  parameter int BG_W      = 2,
  parameter int RANK_W    = 1,
  parameter int RULE_W    = $clog2(NUM_RULES),
  parameter int CFG_AW    = RULE_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlatStrobe_t       strobe,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              errQ,
  output logic [CH_W-1:0]   physChQ,
  output logic [RANK_W-1:0] rankQ,
  output logic [BG_W-1:0]   bgQ,
  output logic [BANK_W-1:0] bankQ,
  output logic [ROW_W-1:0]  rowQ,
  output logic [COL_W-1:0]  colQ
);
  localparam int MAP_W      = NUM_CH * CH_W;
  localparam int BANK_LSB   = COL_W;
  localparam int BG_LSB     = BANK_LSB + BANK_W;
  localparam int ROW_LSB    = BG_LSB + BG_W;
  localparam int RANK_LSB   = ROW_LSB + ROW_W;
  localparam logic [MAP_W-1:0] IDENTITY_MAP = 8'b11_10_01_00;

  logic [ADDR_W-1:0] baseQ  [NUM_RULES];
  logic [ADDR_W-1:0] limitQ [NUM_RULES];
  ruleCtl_t          ctlQ   [NUM_RULES];
  logic [MAP_W-1:0]  mapQ;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        baseQ[i]  <= '0;
        limitQ[i] <= '0;
        ctlQ[i]   <= '0;
      end
      mapQ <= IDENTITY_MAP;
    end else if (cfgWe) begin
      if (cfgAddr[CFG_AW-1]) begin
        mapQ <= cfgData[MAP_W-1:0];
      end else begin
        case (cfgAddr[1:0])
          2'd0:    baseQ[cfgAddr[CFG_AW-2:2]]  <= cfgData;
          2'd1:    limitQ[cfgAddr[CFG_AW-2:2]] <= cfgData;
          2'd2:    ctlQ[cfgAddr[CFG_AW-2:2]]   <= ruleCtl_t'(cfgData[CTL_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  // window comparators
  logic [NUM_RULES-1:0] hitVec;
  for (genvar g = 0; g < NUM_RULES; g++) begin : gRange
    chan_xlat_range #(.ADDR_W(ADDR_W)) uRange (
      .en   (ctlQ[g].en),
      .addr (reqAddr),
      .base (baseQ[g]),
      .limit(limitQ[g]),
      .hit  (hitVec[g])
    );
  end

  // lowest-numbered hit wins
  logic              anyHit;
  logic [RULE_W-1:0] selIdx;
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        selIdx = RULE_W'(i);
      end
    end
  end

  ruleCtl_t          selCtl;
  logic [1:0]        nSel;
  logic [1:0]        selMask;
  logic [1:0]        listIdx;
  logic [CH_W-1:0]   logCh;
  logic [CH_W-1:0]   physCh;
  logic [POS_W:0]    shAmt;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] squeezed;
  logic [ADDR_W-1:0] chAddr;

  always_comb begin
    selCtl = ctlQ[selIdx];
    case (selCtl.waysCode)
      2'd0:    begin nSel = 2'd0; selMask = 2'b00; end
      2'd1:    begin nSel = 2'd1; selMask = 2'b01; end
      default: begin nSel = 2'd2; selMask = 2'b11; end
    endcase
    listIdx  = 2'(reqAddr >> selCtl.selPos) & selMask;
    logCh    = selCtl.list[{listIdx, 1'b0} +: CH_W];
    physCh   = mapQ[{logCh, 1'b0} +: CH_W];
    shAmt    = {1'b0, selCtl.selPos} + (POS_W+1)'(nSel);
    lowMask  = (ADDR_W'(1) << selCtl.selPos) - ADDR_W'(1);
    squeezed = ((reqAddr >> shAmt) << selCtl.selPos) | (reqAddr & lowMask);
    chAddr   = squeezed >> OFF_W;
  end

  // registered response fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ    <= 1'b0;
      physChQ <= '0;
      rankQ   <= '0;
      bgQ     <= '0;
      bankQ   <= '0;
      rowQ    <= '0;
      colQ    <= '0;
    end else if (strobe.load) begin
      errQ <= !anyHit;
      if (anyHit) begin
        physChQ <= physCh;
        colQ    <= COL_W'(chAddr);
        bankQ   <= BANK_W'(chAddr >> BANK_LSB);
        bgQ     <= BG_W'(chAddr >> BG_LSB);
        rowQ    <= ROW_W'(chAddr >> ROW_LSB);
        rankQ   <= RANK_W'(chAddr >> RANK_LSB);
      end else begin
        physChQ <= '0;
        colQ    <= '0;
        bankQ   <= '0;
        bgQ     <= '0;
        rowQ    <= '0;
        rankQ   <= '0;
      end
    end else if (strobe.drain) begin
      errQ    <= 1'b0;
      physChQ <= '0;
      rankQ   <= '0;
      bgQ     <= '0;
      bankQ   <= '0;
      rowQ    <= '0;
      colQ    <= '0;
    end
  end
endmodule

// File: rtl/chan_addr_xlat.sv
module chan_addr_xlat
  import chan_xlat_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NUM_RULES = 8,
  parameter int ROW_W     = 17,
  parameter int BG_W      = 2,
  parameter int RANK_W    = 1,
  parameter int RULE_W    = $clog2(NUM_RULES),
  parameter int CFG_AW    = RULE_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              respValid,
  input  logic              respReady,
  output logic              respErr,
  output logic [1:0]        respPhysCh,
  output logic [RANK_W-1:0] respRank,
  output logic [BG_W-1:0]   respBankGroup,
  output logic [1:0]        respBank,
  output logic [ROW_W-1:0]  respRow,
  output logic [9:0]        respCol
);
  xlatStrobe_t strobe;

  chan_xlat_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .respReady(respReady),
    .reqReady (reqReady),
    .respValid(respValid),
    .strobe   (strobe)
  );

  chan_xlat_dp #(
    .ADDR_W(ADDR_W), .NUM_RULES(NUM_RULES), .ROW_W(ROW_W),
    .BG_W(BG_W), .RANK_W(RANK_W), .RULE_W(RULE_W), .CFG_AW(CFG_AW)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .cfgData(cfgData),
    .reqAddr(reqAddr),
    .errQ   (respErr),
    .physChQ(respPhysCh),
    .rankQ  (respRank),
    .bgQ    (respBankGroup),
    .bankQ  (respBank),
    .rowQ   (respRow),
    .colQ   (respCol)
  );
endmodule

// File: rtl/chan_xlat_chk.sv
module chan_xlat_chk #(
  parameter int ROW_W  = 17,
  parameter int BG_W   = 2,
  parameter int RANK_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              respValid,
  input logic              respReady,
  input logic              respErr,
  input logic [1:0]        respPhysCh,
  input logic [RANK_W-1:0] respRank,
  input logic [BG_W-1:0]   respBankGroup,
  input logic [1:0]        respBank,
  input logic [ROW_W-1:0]  respRow,
  input logic [9:0]        respCol
);
  logic fieldsZero;
  assign fieldsZero = (respPhysCh == '0) && (respRank == '0) && (respBankGroup == '0)
                   && (respBank == '0) && (respRow == '0) && (respCol == '0);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respReady |=> respValid && $stable(respErr) && $stable(respPhysCh)
      && $stable(respRank) && $stable(respBankGroup) && $stable(respBank)
      && $stable(respRow) && $stable(respCol));

  // R9
  blocked_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respReady |-> !reqReady);

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respErr |-> fieldsZero);

  // R10
  accept_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> respValid);

  // R10
  drain_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    respReady |-> reqReady);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> fieldsZero && !respErr);
endmodule

bind chan_addr_xlat chan_xlat_chk #(.ROW_W(ROW_W), .BG_W(BG_W), .RANK_W(RANK_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respReady(respReady), .respErr(respErr),
  .respPhysCh(respPhysCh), .respRank(respRank), .respBankGroup(respBankGroup),
  .respBank(respBank), .respRow(respRow), .respCol(respCol)
);

// File: tb/chan_addr_xlat_test.sv
`timescale 1ns/1ps
module chan_addr_xlat_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [39:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [39:0] reqAddr = '0;
  logic        reqReady, respValid, respErr;
  logic        respReady = 1'b1;
  logic [1:0]  respPhysCh, respBankGroup, respBank;
  logic [0:0]  respRank;
  logic [16:0] respRow;
  logic [9:0]  respCol;

  always #2.5 clk = ~clk;

  chan_addr_xlat uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .respValid(respValid), .respReady(respReady), .respErr(respErr),
    .respPhysCh(respPhysCh), .respRank(respRank), .respBankGroup(respBankGroup),
    .respBank(respBank), .respRow(respRow), .respCol(respCol)
  );

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string curReq = "R1";

  // reference model state
  longint unsigned mBase [8];
  longint unsigned mLimit [8];
  longint unsigned mCtl [8];
  int    mMap [4];
  bit    mValid, eErr;
  int    ePh, eRank, eBg, eBank, eRow, eCol;

  function automatic void predict(input longint unsigned a, output bit err,
                                  output int ph, output int rank, output int bg,
                                  output int bank, output int row, output int col);
    int hit = -1;
    int n, pos, idx, lch, k;
    longint unsigned s, c;
    for (int r = 0; r < 8; r++)
      if (hit < 0 && mCtl[r][0] && a >= mBase[r] && a <= mLimit[r]) hit = r;
    err = 0; ph = 0; rank = 0; bg = 0; bank = 0; row = 0; col = 0;
    if (hit < 0) begin err = 1; return; end
    case ((mCtl[hit] >> 1) & 3)
      0: n = 0;
      1: n = 1;
      default: n = 2;
    endcase
    pos = int'((mCtl[hit] >> 3) & 63);
    idx = int'((a >> pos) & ((64'd1 << n) - 1));
    lch = int'((mCtl[hit] >> (9 + 2 * idx)) & 3);
    ph  = mMap[lch];
    s = 0; k = 0;
    for (int b = 0; b < 40; b++) begin
      if (b < pos || b >= pos + n) begin
        if (a[b]) s = s | (64'd1 << k);
        k++;
      end
    end
    c    = s >> 3;
    col  = int'(c & 1023);
    bank = int'((c >> 10) & 3);
    bg   = int'((c >> 12) & 3);
    row  = int'((c >> 14) & 17'h1FFFF);
    rank = int'((c >> 31) & 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin mBase[i] = 0; mLimit[i] = 0; mCtl[i] = 0; end
      for (int i = 0; i < 4; i++) mMap[i] = i;
      mValid = 0; eErr = 0; ePh = 0; eRank = 0; eBg = 0; eBank = 0; eRow = 0; eCol = 0;
    end else begin
      if (reqValid && (!mValid || respReady)) begin
        mValid = 1;
        predict(reqAddr, eErr, ePh, eRank, eBg, eBank, eRow, eCol);
      end else if (mValid && respReady) begin
        mValid = 0; eErr = 0; ePh = 0; eRank = 0; eBg = 0; eBank = 0; eRow = 0; eCol = 0;
      end
      if (cfgWe) begin
        if (cfgAddr[5]) begin
          for (int i = 0; i < 4; i++) mMap[i] = int'((cfgData >> (2 * i)) & 3);
        end else begin
          case (cfgAddr[1:0])
            2'd0: mBase[cfgAddr[4:2]]  = cfgData;
            2'd1: mLimit[cfgAddr[4:2]] = cfgData;
            2'd2: mCtl[cfgAddr[4:2]]   = cfgData;
            default: ;
          endcase
        end
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge (R11 covered by zero fields when idle)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (respValid !== mValid || reqReady !== (!mValid || respReady) ||
          respErr !== eErr || respPhysCh !== 2'(ePh) || respRank !== 1'(eRank) ||
          respBankGroup !== 2'(eBg) || respBank !== 2'(eBank) ||
          respRow !== 17'(eRow) || respCol !== 10'(eCol)) begin
        failures++;
        $display("FAIL %s t=%0t actual v=%0d rdy=%0d err=%0d ph=%0d rk=%0d bg=%0d bk=%0d row=%0h col=%0h expected v=%0d rdy=%0d err=%0d ph=%0d rk=%0d bg=%0d bk=%0d row=%0h col=%0h",
                 curReq, $time, respValid, reqReady, respErr, respPhysCh, respRank,
                 respBankGroup, respBank, respRow, respCol, mValid, !mValid || respReady,
                 eErr, ePh, eRank, eBg, eBank, eRow, eCol);
      end
    end
  end

  task automatic cfgWrite(input int a, input longint unsigned d);
    @(posedge clk); #1;
    cfgWe = 1; cfgAddr = 6'(a); cfgData = 40'(d);
    @(posedge clk); #1;
    cfgWe = 0;
  endtask

  function automatic longint unsigned ctlWord(input int en, input int ways, input int pos,
                                              input int l0, input int l1, input int l2, input int l3);
    return longint'(en) | (longint'(ways) << 1) | (longint'(pos) << 3) | (longint'(l0) << 9)
         | (longint'(l1) << 11) | (longint'(l2) << 13) | (longint'(l3) << 15);
  endfunction

  task automatic setRule(input int r, input longint unsigned b, input longint unsigned l,
                         input longint unsigned c);
    cfgWrite(r * 4 + 0, b);
    cfgWrite(r * 4 + 1, l);
    cfgWrite(r * 4 + 2, c);
  endtask

  task automatic send(input longint unsigned a);
    @(posedge clk); #1;
    reqValid = 1; reqAddr = 40'(a);
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired in phase %s", curReq);
    endRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: reset state, then a request with every window disabled
    curReq = "R1";
    @(negedge clk);
    checks++;
    if (reqReady !== 1'b1 || respValid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset actual rdy=%0d v=%0d expected rdy=1 v=0", reqReady, respValid);
    end
    send(40'h12_3456_7840);
    repeat (2) @(posedge clk);

    // R8: program windows; R2: inclusive bounds and priority
    curReq = "R8";
    setRule(0, 40'h1000_0000, 40'h1FFF_FFFF, ctlWord(1, 1, 6, 1, 2, 0, 0));
    setRule(1, 40'h0, 40'h3FFF_FFFF, ctlWord(1, 2, 8, 3, 2, 1, 0));
    setRule(2, 40'h40_0000_0000 - 40'h1000, 40'hFF_FFFF_FFFF, ctlWord(0, 0, 0, 0, 0, 0, 0));
    curReq = "R2";
    send(40'h1800_0040); send(40'h1000_0000); send(40'h1FFF_FFFF);
    send(40'h0FFF_FFFF); send(40'h2000_0000); send(40'h2000_0140);
    // R3: miss, including a disabled window
    curReq = "R3";
    send(40'h4000_0000); send(40'h3F_FFFF_F000);
    // R4: four-way selector values and one-way
    curReq = "R4";
    for (int i = 0; i < 4; i++) send(40'h0200_0000 + (i << 8));
    setRule(3, 40'h80_0000_0000, 40'h80_FFFF_FFFF, ctlWord(1, 0, 20, 2, 3, 1, 0));
    setRule(4, 40'h90_0000_0000, 40'h90_FFFF_FFFF, ctlWord(1, 3, 12, 0, 1, 2, 3));
    send(40'h80_1234_5678); send(40'h90_0000_3000); send(40'h90_0000_1000);
    // R5: permuted channel map
    curReq = "R5";
    cfgWrite(32, 8'b00_01_11_10);
    for (int i = 0; i < 4; i++) send(40'h90_0000_0000 + (i << 12));
    // R6 and R7: squeeze and field layout with dense bit patterns
    curReq = "R6";
    send(40'h1FFF_FFFF); send(40'h1555_5555); send(40'h1AAA_AAAA);
    curReq = "R7";
    send(40'h80_FFFF_FFFF); send(40'h90_AAAA_5555);
    // R9: backpressure
    curReq = "R9";
    @(posedge clk); #1 respReady = 0;
    @(posedge clk); #1 reqValid = 1; reqAddr = 40'h1234_5678;
    repeat (4) @(posedge clk);
    #1 reqAddr = 40'h1000_0080;
    repeat (3) @(posedge clk);
    #1 respReady = 1;
    @(posedge clk); #1 reqValid = 0;
    repeat (2) @(posedge clk);
    // R10: streaming with ready high, then random mix (R11 on idle cycles)
    curReq = "R10";
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      reqValid = 1; reqAddr = 40'({$urandom} % 32'h5000_0000);
    end
    @(posedge clk); #1 reqValid = 0;
    curReq = "R11";
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      reqValid  = ($urandom % 3) != 0;
      respReady = ($urandom % 4) != 0;
      reqAddr   = ($urandom % 5 == 0) ? {8'h90, 32'($urandom)} : 40'({$urandom} % 32'h5000_0000);
      if (i == 200) begin
        reqValid = 0;
        cfgWe = 1; cfgAddr = 6'd2; cfgData = 40'(ctlWord(1, 2, 7, 2, 0, 3, 1));
        @(posedge clk); #1 cfgWe = 0;
      end
    end
    @(posedge clk); #1 reqValid = 0; respReady = 1;
    repeat (4) @(posedge clk);
    endRun();
  end
endmodule